// File: doc/BRIEF.md
# Multiplexed Bus Latch Write Sequencer

This block lets FPGA logic load a set of external 16-bit latches that present address, data and control words to a slow host bus, using a single shared 16-bit output bus and one strobe line. The strobe is wired two ways outside the chip. Its rising edge clocks an 8-bit select code into an external control register. While it is low, the same line holds that register cleared. The register decodes into active-low latch enables, so one strobe pulse first chooses a latch and then frames the window in which that latch's enable is active.

A client hands over a write request with a select code and a 16-bit word on a valid/ready interface. The sequencer then runs four timed phases. First the select code is put on the bus with the strobe low. The strobe is then raised while the code is held. Next the word is placed on the bus with the strobe still high. Finally the strobe is dropped while the word is held. Dropping the strobe clears the register, so the chosen enable rises and the latch takes the word on that edge. Each phase length is a parameter, so the sequence can absorb the board's delay-line skew and still fit many writes inside one host bus cycle.

Top module: `latch_write_seq`

## Requirements
- R1: While reset is asserted, and for LOW_CYC clocks after the two-flop reset release, `lstrobe` is 0, `lbus` is 0 and `req_ready` is 0. `req_ready` then goes to 1.
- R2: A request is taken at a rising clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `req_ready` stays 0 until the strobe-low phase has ended.
- R3: For SEL_CYC cycles after acceptance, `lstrobe` is 0 and `lbus` carries the select code in bits 7:0, with bits 15:8 at 0.
- R4: The strobe then rises and stays high for STB_CYC cycles. During this time `lbus` keeps the select code unchanged, including in the cycle of the rising edge.
- R5: For the next DAT_CYC cycles, `lstrobe` is 1 and `lbus` carries the full 16-bit request word.
- R6: The strobe then falls and stays low for LOW_CYC cycles. `lbus` keeps the word unchanged, including in the cycle of the falling edge.
- R7: `wr_done` is 1 for exactly one cycle, the last cycle of the strobe-low phase. In the following cycle `req_ready` is 1.
- R8: When no write is in progress, `lstrobe` is 0 and `lbus` holds the last word written (0 after reset).
- R9: With an external register that decodes code 0x02 to the address latch, 0x04 to the data latch and 0x08 to the control latch (all enables active low, latches capture on the enable's rising edge), a write loads its word into the selected latch only. A code that matches none of these leaves every latch unchanged.
- R10: A full write takes SEL_CYC+STB_CYC+DAT_CYC+LOW_CYC cycles from the acceptance edge to the end of the `wr_done` cycle.
- R11: While `req_ready` is 0, `req_valid` and the request fields are ignored. A request offered and withdrawn during a busy write produces no extra strobe and changes no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Write request offered |
| req_sel | input | 8 | Select code to load into the external control register |
| req_word | input | 16 | Word to load into the selected latch |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| wr_done | output | 1 | One-cycle pulse at the end of a write |
| lbus | output | 16 | Shared bus to the control register and the latches |
| lstrobe | output | 1 | Register clock and clear, and latch-enable framing strobe |

## Verification
The bench builds the sequencer with select, strobe-high, data and strobe-low phases of 2, 3, 2 and 2 cycles. Because all four lengths differ from the defaults, and from their neighbours where that matters, a phase that is too short, too long or swapped with another moves a bus or strobe transition by at least one sampled cycle. Multi-cycle phases also make the hold of the select byte after the strobe rises, and of the word after the strobe falls, visible over several cycles. A behavioural model of the control register, the enable decoding and the edge-triggered latches then shows which latch each sequence actually loads, including codes that select nothing.

// File: rtl/lws_pkg.sv
package lws_pkg;

  typedef enum logic [2:0] {
    PH_INIT = 3'd0,
    PH_IDLE = 3'd1,
    PH_SEL  = 3'd2,
    PH_STB  = 3'd3,
    PH_DAT  = 3'd4,
    PH_LOW  = 3'd5
  } phase_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/lws_rst_sync.sv
module lws_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/lws_phase_timer.sv
module lws_phase_timer #(
  parameter int unsigned CNT_W    = 2,
  parameter int unsigned INIT_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)            cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(INIT_VAL);
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // each new phase starts only once the previous one has run its full length (R10)
  assert_load_after_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> expired);
endmodule

// File: rtl/lws_ctrl.sv
module lws_ctrl
  import lws_pkg::*;
#(
  parameter int unsigned CNT_W   = 2,
  parameter int unsigned SEL_CYC = 1,
  parameter int unsigned STB_CYC = 2,
  parameter int unsigned DAT_CYC = 1,
  parameter int unsigned LOW_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             expired,
  output phase_e           phase_q,
  output phase_e           phase_d,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             ready,
  output logic             done
);

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = '0;
    unique case (phase_q)
      PH_INIT: if (expired) phase_d = PH_IDLE;
      PH_IDLE: if (req_valid) begin
        phase_d  = PH_SEL;
        load     = 1'b1;
        load_val = CNT_W'(SEL_CYC - 1);
      end
      PH_SEL: if (expired) begin
        phase_d  = PH_STB;
        load     = 1'b1;
        load_val = CNT_W'(STB_CYC - 1);
      end
      PH_STB: if (expired) begin
        phase_d  = PH_DAT;
        load     = 1'b1;
        load_val = CNT_W'(DAT_CYC - 1);
      end
      PH_DAT: if (expired) begin
        phase_d  = PH_LOW;
        load     = 1'b1;
        load_val = CNT_W'(LOW_CYC - 1);
      end
      PH_LOW: if (expired) phase_d = PH_IDLE;
      default: phase_d = PH_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_INIT;
    else        phase_q <= phase_d;
  end

  assign ready = (phase_q == PH_IDLE);
  assign done  = (phase_q == PH_LOW) && expired;

  assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready) |=> !ready);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && ready));

  assert_done_not_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ready);
endmodule

// File: rtl/lws_bus_drive.sv
module lws_bus_drive
  import lws_pkg::*;
#(
  parameter int unsigned SEL_W  = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_q,
  input  phase_e            phase_d,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [DATA_W-1:0] req_word,
  output logic [DATA_W-1:0] bus_o,
  output logic              strobe_o
);
  localparam int unsigned PAD_W = DATA_W - SEL_W;

  logic [DATA_W-1:0] word_q, bus_q, bus_d;
  logic              strobe_q, strobe_d;
  logic              accept, to_data, word_en, bus_en;

  assign accept  = (phase_q == PH_IDLE) && (phase_d == PH_SEL);
  assign to_data = (phase_q == PH_STB) && (phase_d == PH_DAT);
  assign word_en = accept;
  assign bus_en  = accept || to_data;

  always_comb begin
    bus_d    = accept ? {{PAD_W{1'b0}}, req_sel} : word_q;
    strobe_d = (phase_d == PH_STB) || (phase_d == PH_DAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      bus_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      if (word_en) word_q <= req_word;
      if (bus_en)  bus_q  <= bus_d;
      strobe_q <= strobe_d;
    end
  end

  assign bus_o    = bus_q;
  assign strobe_o = strobe_q;

  assert_sel_held_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_q) |-> $stable(bus_q));

  assert_word_held_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_q) |-> $stable(bus_q));

  assert_strobe_min_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_q) |=> strobe_q);
endmodule

// File: rtl/latch_write_seq.sv
module latch_write_seq
  import lws_pkg::*;
#(
  parameter int unsigned SEL_W   = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SEL_CYC = 1,
  parameter int unsigned STB_CYC = 2,
  parameter int unsigned DAT_CYC = 1,
  parameter int unsigned LOW_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [DATA_W-1:0] req_word,
  output logic              req_ready,
  output logic              wr_done,
  output logic [DATA_W-1:0] lbus,
  output logic              lstrobe
);
  localparam int unsigned MAX_CYC = max4(SEL_CYC, STB_CYC, DAT_CYC, LOW_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             rst_n_i;
  logic             expired, load;
  logic [CNT_W-1:0] load_val;
  phase_e           phase_q, phase_d;

  lws_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_i)
  );

  lws_phase_timer #(
    .CNT_W    (CNT_W),
    .INIT_VAL (LOW_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  lws_ctrl #(
    .CNT_W   (CNT_W),
    .SEL_CYC (SEL_CYC),
    .STB_CYC (STB_CYC),
    .DAT_CYC (DAT_CYC),
    .LOW_CYC (LOW_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .req_valid (req_valid),
    .expired   (expired),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .load      (load),
    .load_val  (load_val),
    .ready     (req_ready),
    .done      (wr_done)
  );

  lws_bus_drive #(
    .SEL_W  (SEL_W),
    .DATA_W (DATA_W)
  ) u_drive (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .phase_q  (phase_q),
    .phase_d  (phase_d),
    .req_sel  (req_sel),
    .req_word (req_word),
    .bus_o    (lbus),
    .strobe_o (lstrobe)
  );

  assert_idle_strobe_low_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    req_ready |-> !lstrobe);

  assert_done_strobe_low_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    wr_done |-> !lstrobe);
endmodule

// File: tb/latch_write_seq_tb.sv
module latch_write_seq_tb;
  localparam int SC = 2;
  localparam int BC = 3;
  localparam int DC = 2;
  localparam int LC = 2;
  localparam int NW = SC + BC + DC + LC;
  localparam logic [23:0] CODES = {8'h08, 8'h04, 8'h02};

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [7:0]  req_sel;
  logic [15:0] req_word;
  logic        req_ready;
  logic        wr_done;
  logic [15:0] lbus;
  logic        lstrobe;

  int n_chk;
  int n_bad;

  latch_write_seq #(
    .SEL_W(8), .DATA_W(16), .SEL_CYC(SC), .STB_CYC(BC), .DAT_CYC(DC), .LOW_CYC(LC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_word(req_word), .req_ready(req_ready), .wr_done(wr_done),
    .lbus(lbus), .lstrobe(lstrobe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // external control register, enable decode and latches
  logic [7:0]  ctl_reg;
  logic [2:0]  en_n;
  logic [15:0] lat_q [3];
  logic [15:0] exp_lat [3];

  always @(posedge lstrobe or negedge lstrobe) begin
    if (!lstrobe) ctl_reg <= 8'h00;
    else          ctl_reg <= lbus[7:0];
  end

  for (genvar k = 0; k < 3; k++) begin : g_lat
    assign en_n[k] = (ctl_reg != CODES[k*8 +: 8]);
    always @(posedge en_n[k]) lat_q[k] <= lbus;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_latches(input string req);
    for (int k = 0; k < 3; k++)
      chk(lat_q[k] === exp_lat[k], req, {16'h0, lat_q[k]}, {16'h0, exp_lat[k]});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_sel = 8'h00;
    req_word = 16'h0000;
    repeat (3) @(negedge clk);
    chk(lbus === 16'h0 && lstrobe === 1'b0, "R1 outputs in reset", {15'h0, lstrobe, lbus}, 32'h0);
    chk(req_ready === 1'b0 && wr_done === 1'b0, "R1 ready/done in reset",
        {30'h0, req_ready, wr_done}, 32'h0);
    rst_n = 1'b1;
    for (int j = 1; j <= 1 + LC; j++) begin
      @(negedge clk);
      chk(req_ready === 1'b0 && lstrobe === 1'b0 && lbus === 16'h0, "R1 hold-off after release",
          {14'h0, req_ready, lstrobe, lbus}, 32'h0);
    end
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after hold-off", {31'h0, req_ready}, 32'h1);
    for (int k = 0; k < 3; k++) exp_lat[k] = lat_q[k];
  endtask

  // tgt: latch index loaded by sel, or -1 when sel matches no latch
  task automatic t_write(input logic [7:0] sel, input logic [15:0] word,
                         input int tgt, input bit intrude);
    logic        e_stb;
    logic [15:0] e_bus;
    string       tag;
    @(negedge clk);
    chk(req_ready === 1'b1, "R2 ready before request", {31'h0, req_ready}, 32'h1);
    req_valid = 1'b1;
    req_sel   = sel;
    req_word  = word;
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      if (i < SC)                begin e_stb = 1'b0; e_bus = {8'h00, sel}; tag = "R3 select phase"; end
      else if (i < SC + BC)      begin e_stb = 1'b1; e_bus = {8'h00, sel}; tag = "R4 strobe high with select"; end
      else if (i < SC + BC + DC) begin e_stb = 1'b1; e_bus = word;         tag = "R5 data phase"; end
      else                       begin e_stb = 1'b0; e_bus = word;         tag = "R6 strobe low with word"; end
      chk(lstrobe === e_stb && lbus === e_bus, tag, {15'h0, lstrobe, lbus}, {15'h0, e_stb, e_bus});
      chk(req_ready === 1'b0, "R2 ready low while busy", {31'h0, req_ready}, 32'h0);
      chk(wr_done === (i == NW - 1), "R7 R10 done pulse timing", {31'h0, wr_done},
          {31'h0, (i == NW - 1)});
      if (i == 0) req_valid = 1'b0;
      if (intrude && i == 1) begin
        req_valid = 1'b1;
        req_sel   = 8'h04;
        req_word  = ~word;
      end
      if (intrude && i == NW - 1) req_valid = 1'b0;
    end
    @(negedge clk);
    chk(req_ready === 1'b1 && wr_done === 1'b0, "R7 ready after done",
        {30'h0, req_ready, wr_done}, 32'h2);
    chk(lstrobe === 1'b0 && lbus === word, "R8 idle bus holds word",
        {15'h0, lstrobe, lbus}, {16'h0, word});
    if (tgt >= 0) exp_lat[tgt] = word;
    chk_latches("R9 latch contents");
  endtask

  task automatic t_idle_after_intrude(input logic [15:0] word);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(lstrobe === 1'b0 && lbus === word && req_ready === 1'b1, "R11 busy request ignored",
          {14'h0, req_ready, lstrobe, lbus}, {14'h2, 1'b0, word});
    end
    chk_latches("R11 no latch change");
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    t_reset();
    t_write(8'h02, 16'h1234, 0, 1'b0);   // address latch
    t_write(8'h04, 16'hABCD, 1, 1'b0);   // data latch
    t_write(8'h08, 16'h5A5A, 2, 1'b0);   // control latch
    t_write(8'h02, 16'hFFFF, 0, 1'b0);   // overwrite address latch
    t_write(8'h02, 16'h0000, 0, 1'b0);
    t_write(8'h10, 16'hC3C3, -1, 1'b0);  // code matching no latch
    t_write(8'h06, 16'h7E7E, -1, 1'b0);  // two enable bits set, still no match
    t_write(8'h08, 16'h8001, 2, 1'b1);   // request offered while busy
    t_idle_after_intrude(16'h8001);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule